// File: doc/BRIEF.md
# Outstanding Miss Table with Request Merging

This block keeps track of the second-level cache misses that one processor has in flight. It holds a small, fully associative table. Each entry stands for one pending line and stores the line address, the kind of request that opened it, the victim way picked for the fill, the most recent virtual address and an ordered list of the first-level miss identifiers that wait for the line. When the second-level controller misses, it offers the aligned line address, the request kind (bit 0 set means exclusive, bits 1 and 2 are flavour flags that are stored and returned), the victim way, the waiter identifier and the virtual address. In the same cycle the block answers with a two-bit outcome and an entry index.

Each entry is a two-state machine. `SLOT_FREE` moves to `SLOT_BUSY` on the *open* transition, when an allocation succeeds into that slot. `SLOT_BUSY` loops on the *join* transition, when a merge appends a waiter. It returns to `SLOT_FREE` on the *release* transition, when the free port names the slot. When the fill completes, the controller presents the entry index on the free port. It reads back the waiter list, the way, the kind, the aligned address and the virtual address in that cycle. The slot is then released at the clock edge.

Top module: `msht_table`

## Requirements
- R1: After reset every slot is free and `occupancy` reads 0.
- R2: An allocation whose aligned line matches no pending slot, while at least one slot is free, returns status 0 (success) with the lowest-numbered free slot as index. That slot then holds the request with a waiter count of 1, and `occupancy` rises by one after the clock edge.
- R3: An allocation that matches no pending slot while all slots are busy returns status 1 (full). Nothing is stored and `occupancy` is unchanged.
- R4: Addresses are compared after the low `ALIGN_BITS` bits are cleared. A request is merged if its line is pending, the pending kind covers it (the pending kind is exclusive, or the new kind is shared, with kind bit 0 meaning exclusive) and the slot has fewer than `WAITERS` waiters. A merge returns status 2 with the pending slot's index, appends the identifier at the end of the waiter list and replaces the stored virtual address.
- R5: A request for a pending line whose shared pending kind cannot cover an exclusive request returns status 3 (conflict) with the pending slot's index, and changes nothing.
- R6: A request that the kind would allow to merge returns status 3 (conflict) when the pending slot already holds `WAITERS` waiters.
- R7: While `free_valid` names a busy slot, the free outputs show its waiters in arrival order (waiter k in bits k*ID_W upward), the waiter count, the way, the kind, the aligned address and the latest virtual address. After the edge the slot is free and `occupancy` has dropped by one.
- R8: Freeing a slot that is not in use leaves `occupancy` and the table unchanged.
- R9: When an allocation and a free occur in the same cycle, the slot being freed is left out of matching and is not reused in that cycle. `occupancy` becomes the old value plus one for a success, minus one for a live release.
- R10: The status encoding is 0 success, 1 full, 2 merge, 3 conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request this cycle |
| alloc_addr | input | ADDR_W | Physical miss address, not yet aligned |
| alloc_kind | input | KIND_W | Bit 0 exclusive; bits 1..2 flavour flags |
| alloc_way | input | WAY_W | Victim way chosen for the fill |
| alloc_id | input | ID_W | First-level miss identifier of the requester |
| alloc_vaddr | input | VA_W | Virtual address of the requester |
| alloc_status | output | 2 | Outcome code (R10) |
| alloc_index | output | IDX_W | Slot that was opened, joined or conflicted |
| free_valid | input | 1 | Release request this cycle |
| free_index | input | IDX_W | Slot to release |
| free_waiters | output | WAITERS*ID_W | Waiter identifiers of the named slot |
| free_wcount | output | CNT_W | Number of waiters in the named slot |
| free_way | output | WAY_W | Stored victim way |
| free_kind | output | KIND_W | Stored request kind |
| free_addr | output | ADDR_W | Stored aligned line address |
| free_vaddr | output | VA_W | Latest stored virtual address |
| occupancy | output | OCC_W | Number of busy slots |

## Verification
A slot whose state machine is stuck busy or dropped early shows up at the next allocation to that line, as a merge where a success was due or the reverse, and from the very next cycle as an occupancy off by one. A waiter list that is written at the wrong position or counted wrongly only appears when the slot is read out on the free port. For that reason every merge sequence in the bench ends with a free, so the corruption becomes visible within a few cycles. The whole kind-pair space, with flavour bits included, is swept against pending slots, and the sweep uses a mirror of the table kept in the bench.

// File: rtl/msht_pkg.sv
package msht_pkg;
    typedef enum logic [1:0] {
        ALLOC_OK       = 2'd0,
        ALLOC_FULL     = 2'd1,
        ALLOC_MERGE    = 2'd2,
        ALLOC_CONFLICT = 2'd3
    } alloc_status_e;

    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_BUSY = 1'b1
    } slot_state_e;

    localparam int KIND_W   = 3;
    localparam int EXCL_BIT = 0;
endpackage

// File: rtl/msht_slot.sv
module msht_slot
    import msht_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int WAY_W   = 2,
    parameter int ID_W    = 3,
    parameter int VA_W    = 32,
    parameter int WAITERS = 4,
    parameter int CNT_W   = $clog2(WAITERS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take_new,
    input  logic                    take_join,
    input  logic                    release_i,
    input  logic [ADDR_W-1:0]       req_line,
    input  logic [KIND_W-1:0]       req_kind,
    input  logic [WAY_W-1:0]        req_way,
    input  logic [ID_W-1:0]         req_id,
    input  logic [VA_W-1:0]         req_vaddr,
    output logic                    busy,
    output logic [ADDR_W-1:0]       line_o,
    output logic [KIND_W-1:0]       kind_o,
    output logic [WAY_W-1:0]        way_o,
    output logic [VA_W-1:0]         vaddr_o,
    output logic [CNT_W-1:0]        wcount_o,
    output logic [WAITERS*ID_W-1:0] waiters_o
);
    slot_state_e state_q, state_d;

    logic [ADDR_W-1:0] line_q;
    logic [KIND_W-1:0] kind_q;
    logic [WAY_W-1:0]  way_q;
    logic [VA_W-1:0]   vaddr_q;
    logic [CNT_W-1:0]  count_q;
    logic [ID_W-1:0]   wait_q [WAITERS];

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: if (take_new)  state_d = SLOT_BUSY;
            SLOT_BUSY: if (release_i) state_d = SLOT_FREE;
            default:                  state_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    // payload follows the transition taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q  <= '0;
            kind_q  <= '0;
            way_q   <= '0;
            vaddr_q <= '0;
            count_q <= '0;
            for (int k = 0; k < WAITERS; k++) wait_q[k] <= '0;
        end else if (state_q == SLOT_FREE && take_new) begin
            line_q    <= req_line;
            kind_q    <= req_kind;
            way_q     <= req_way;
            vaddr_q   <= req_vaddr;
            wait_q[0] <= req_id;
            count_q   <= CNT_W'(1);
        end else if (state_q == SLOT_BUSY && release_i) begin
            count_q <= '0;
        end else if (state_q == SLOT_BUSY && take_join) begin
            for (int k = 0; k < WAITERS; k++)
                if (CNT_W'(k) == count_q) wait_q[k] <= req_id;
            count_q <= count_q + CNT_W'(1);
            vaddr_q <= req_vaddr;
        end
    end

    assign busy     = (state_q == SLOT_BUSY);
    assign line_o   = line_q;
    assign kind_o   = kind_q;
    assign way_o    = way_q;
    assign vaddr_o  = vaddr_q;
    assign wcount_o = count_q;

    for (genvar k = 0; k < WAITERS; k++) begin : g_pack
        assign waiters_o[k*ID_W +: ID_W] = wait_q[k];
    end

    AST_OPEN_FROM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        take_new |-> !busy);                                              // R2
    AST_OPEN_ONE_WAITER: assert property (@(posedge clk) disable iff (!rst_n)
        (take_new && !busy) |=> (busy && wcount_o == CNT_W'(1)));         // R2
    AST_JOIN_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        take_join |-> (busy && wcount_o < CNT_W'(WAITERS) && !release_i)); // R6
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (wcount_o >= CNT_W'(1) && wcount_o <= CNT_W'(WAITERS))); // R6
endmodule

// File: rtl/msht_lookup.sv
module msht_lookup #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 32,
    parameter int WAITERS = 4,
    parameter int CNT_W   = $clog2(WAITERS + 1)
) (
    input  logic [ENTRIES-1:0] busy_i,
    input  logic [ENTRIES-1:0] skip_i,
    input  logic [ENTRIES-1:0] excl_i,
    input  logic [ADDR_W-1:0]  line_i   [ENTRIES],
    input  logic [CNT_W-1:0]   wcount_i [ENTRIES],
    input  logic [ADDR_W-1:0]  req_line_i,
    input  logic               req_excl_i,
    output logic [ENTRIES-1:0] hit_o,
    output logic [ENTRIES-1:0] join_o
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit_o[i]  = busy_i[i] && !skip_i[i] && (line_i[i] == req_line_i);
        assign join_o[i] = (excl_i[i] || !req_excl_i) &&
                           (wcount_i[i] < CNT_W'(WAITERS));
    end
endmodule

// File: rtl/msht_pick.sv
module msht_pick #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] req_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (req_i[i]) idx_o = IDX_W'(i);
    end
endmodule

// File: rtl/msht_table.sv
module msht_table
    import msht_pkg::*;
#(
    parameter int ENTRIES    = 8,
    parameter int WAITERS    = 4,
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 3,
    parameter int WAY_W      = 2,
    parameter int ID_W       = 3,
    parameter int VA_W       = 32,
    localparam int IDX_W     = $clog2(ENTRIES),
    localparam int CNT_W     = $clog2(WAITERS + 1),
    localparam int OCC_W     = $clog2(ENTRIES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_valid,
    input  logic [ADDR_W-1:0]       alloc_addr,
    input  logic [KIND_W-1:0]       alloc_kind,
    input  logic [WAY_W-1:0]        alloc_way,
    input  logic [ID_W-1:0]         alloc_id,
    input  logic [VA_W-1:0]         alloc_vaddr,
    output logic [1:0]              alloc_status,
    output logic [IDX_W-1:0]        alloc_index,
    input  logic                    free_valid,
    input  logic [IDX_W-1:0]        free_index,
    output logic [WAITERS*ID_W-1:0] free_waiters,
    output logic [CNT_W-1:0]        free_wcount,
    output logic [WAY_W-1:0]        free_way,
    output logic [KIND_W-1:0]       free_kind,
    output logic [ADDR_W-1:0]       free_addr,
    output logic [VA_W-1:0]         free_vaddr,
    output logic [OCC_W-1:0]        occupancy
);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << ALIGN_BITS) - 64'd1);

    logic [ADDR_W-1:0] req_line;
    assign req_line = alloc_addr & ~LOW_MASK;

    logic [ENTRIES-1:0] busy_vec, excl_vec, skip_vec, hit_vec, join_vec;
    logic [ENTRIES-1:0] new_vec, joinsel_vec, rel_vec;
    logic [ADDR_W-1:0]       line_a  [ENTRIES];
    logic [KIND_W-1:0]       kind_a  [ENTRIES];
    logic [WAY_W-1:0]        way_a   [ENTRIES];
    logic [VA_W-1:0]         va_a    [ENTRIES];
    logic [CNT_W-1:0]        cnt_a   [ENTRIES];
    logic [WAITERS*ID_W-1:0] wait_a  [ENTRIES];

    alloc_status_e      status;
    logic [IDX_W-1:0]   pick_idx;
    logic               hit_any, free_any;
    logic [IDX_W-1:0]   hit_idx, free_slot;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        assign skip_vec[i]    = free_valid && (free_index == IDX_W'(i));
        assign excl_vec[i]    = kind_a[i][EXCL_BIT];
        assign new_vec[i]     = alloc_valid && (status == ALLOC_OK)    && (pick_idx == IDX_W'(i));
        assign joinsel_vec[i] = alloc_valid && (status == ALLOC_MERGE) && (pick_idx == IDX_W'(i));
        assign rel_vec[i]     = skip_vec[i];

        msht_slot #(
            .ADDR_W(ADDR_W), .WAY_W(WAY_W), .ID_W(ID_W), .VA_W(VA_W),
            .WAITERS(WAITERS), .CNT_W(CNT_W)
        ) u_slot (
            .clk(clk), .rst_n(rst_n),
            .take_new(new_vec[i]), .take_join(joinsel_vec[i]), .release_i(rel_vec[i]),
            .req_line(req_line), .req_kind(alloc_kind), .req_way(alloc_way),
            .req_id(alloc_id), .req_vaddr(alloc_vaddr),
            .busy(busy_vec[i]), .line_o(line_a[i]), .kind_o(kind_a[i]),
            .way_o(way_a[i]), .vaddr_o(va_a[i]), .wcount_o(cnt_a[i]),
            .waiters_o(wait_a[i])
        );
    end

    msht_lookup #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .WAITERS(WAITERS), .CNT_W(CNT_W)) u_lookup (
        .busy_i(busy_vec), .skip_i(skip_vec), .excl_i(excl_vec),
        .line_i(line_a), .wcount_i(cnt_a),
        .req_line_i(req_line), .req_excl_i(alloc_kind[EXCL_BIT]),
        .hit_o(hit_vec), .join_o(join_vec)
    );

    msht_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick_hit (
        .req_i(hit_vec), .any_o(hit_any), .idx_o(hit_idx)
    );

    msht_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick_free (
        .req_i(~busy_vec), .any_o(free_any), .idx_o(free_slot)
    );

    // outcome decision
    always_comb begin
        status   = ALLOC_FULL;
        pick_idx = '0;
        if (hit_any) begin
            pick_idx = hit_idx;
            status   = join_vec[hit_idx] ? ALLOC_MERGE : ALLOC_CONFLICT;
        end else if (free_any) begin
            pick_idx = free_slot;
            status   = ALLOC_OK;
        end
    end

    assign alloc_status = status;
    assign alloc_index  = pick_idx;

    assign free_waiters = wait_a[free_index];
    assign free_wcount  = cnt_a[free_index];
    assign free_way     = way_a[free_index];
    assign free_kind    = kind_a[free_index];
    assign free_addr    = line_a[free_index];
    assign free_vaddr   = va_a[free_index];

    // occupancy counter
    logic [OCC_W-1:0] occ_q;
    logic             inc_now, dec_now;
    assign inc_now = alloc_valid && (status == ALLOC_OK);
    assign dec_now = free_valid && busy_vec[free_index];

    always_ff @(posedge clk) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_q + OCC_W'(inc_now) - OCC_W'(dec_now);
    end
    assign occupancy = occ_q;

    AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));                                                    // R4
    AST_FULL_ALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && status == ALLOC_FULL) |-> (occ_q == OCC_W'(ENTRIES))); // R3
    AST_OCC_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q == OCC_W'($countones(busy_vec)));                                // R1
    AST_OCC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_now && !dec_now) |=> (occ_q == $past(occ_q) + OCC_W'(1)));        // R9
    AST_FREED_SLOT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        dec_now |=> !busy_vec[$past(free_index)]);                             // R7
endmodule

// File: tb/msht_table_tb.sv
module msht_table_tb;
    localparam int N = 8;
    localparam int W = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [31:0] alloc_addr = '0;
    logic [2:0]  alloc_kind = '0;
    logic [1:0]  alloc_way = '0;
    logic [2:0]  alloc_id = '0;
    logic [31:0] alloc_vaddr = '0;
    logic [1:0]  alloc_status;
    logic [2:0]  alloc_index;
    logic        free_valid = 1'b0;
    logic [2:0]  free_index = '0;
    logic [11:0] free_waiters;
    logic [2:0]  free_wcount;
    logic [1:0]  free_way;
    logic [2:0]  free_kind;
    logic [31:0] free_addr;
    logic [31:0] free_vaddr;
    logic [3:0]  occupancy;

    always #10 clk = ~clk;   // 50 MHz

    msht_table u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_addr(alloc_addr), .alloc_kind(alloc_kind),
        .alloc_way(alloc_way), .alloc_id(alloc_id), .alloc_vaddr(alloc_vaddr),
        .alloc_status(alloc_status), .alloc_index(alloc_index),
        .free_valid(free_valid), .free_index(free_index),
        .free_waiters(free_waiters), .free_wcount(free_wcount), .free_way(free_way),
        .free_kind(free_kind), .free_addr(free_addr), .free_vaddr(free_vaddr),
        .occupancy(occupancy)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // mirror of the table, built from the requirements
    bit          m_busy [N];
    logic [31:0] m_addr [N];
    logic [2:0]  m_kind [N];
    logic [1:0]  m_way  [N];
    logic [31:0] m_va   [N];
    int          m_cnt  [N];
    logic [2:0]  m_w    [N][W];
    int          m_occ = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input bit av, input logic [31:0] addr, input logic [2:0] kind,
                       input logic [1:0] way, input logic [2:0] id, input logic [31:0] va,
                       input bit fv, input int fidx);
        int    hit;
        int    exp_st;
        int    exp_ix;
        string tag;
        logic [31:0] line;
        line = addr & 32'hFFFF_FFF8;
        alloc_valid = av; alloc_addr = addr; alloc_kind = kind; alloc_way = way;
        alloc_id = id; alloc_vaddr = va;
        free_valid = fv; free_index = 3'(fidx);
        #2;
        hit = -1;
        for (int i = 0; i < N; i++)
            if (m_busy[i] && !(fv && fidx == i) && m_addr[i] == line) hit = i;
        exp_ix = 0;
        if (hit >= 0) begin
            exp_ix = hit;
            if (!(m_kind[hit][0] || !kind[0])) begin exp_st = 3; tag = "R5"; end
            else if (m_cnt[hit] >= W)          begin exp_st = 3; tag = "R6"; end
            else                               begin exp_st = 2; tag = "R4"; end
        end else begin
            exp_st = 1; tag = "R3";
            for (int i = N - 1; i >= 0; i--)
                if (!m_busy[i]) begin exp_st = 0; exp_ix = i; tag = "R2"; end
        end
        if (av) begin
            // R10: 0 success, 1 full, 2 merge, 3 conflict
            check(alloc_status == 2'(exp_st), $sformatf("%s/R10", tag), "status",
                  alloc_status, exp_st);
            if (exp_st != 1)
                check(alloc_index == 3'(exp_ix), tag, "index", alloc_index, exp_ix);
        end
        if (fv && m_busy[fidx]) begin
            check(free_wcount == 3'(m_cnt[fidx]), "R7", "wcount", free_wcount, m_cnt[fidx]);
            for (int k = 0; k < m_cnt[fidx]; k++)
                check(free_waiters[k*3 +: 3] == m_w[fidx][k], "R7", $sformatf("waiter%0d", k),
                      free_waiters[k*3 +: 3], m_w[fidx][k]);
            check(free_way == m_way[fidx] && free_kind == m_kind[fidx], "R7", "way/kind",
                  {free_way, free_kind}, {m_way[fidx], m_kind[fidx]});
            check(free_addr == m_addr[fidx] && free_vaddr == m_va[fidx], "R7", "addr/vaddr",
                  free_vaddr, m_va[fidx]);
        end
        @(posedge clk);
        if (fv && m_busy[fidx]) begin m_busy[fidx] = 0; m_cnt[fidx] = 0; m_occ--; end
        if (av && exp_st == 0) begin
            m_busy[exp_ix] = 1; m_addr[exp_ix] = line; m_kind[exp_ix] = kind;
            m_way[exp_ix] = way; m_va[exp_ix] = va; m_cnt[exp_ix] = 1;
            m_w[exp_ix][0] = id; m_occ++;
        end else if (av && exp_st == 2) begin
            m_w[exp_ix][m_cnt[exp_ix]] = id; m_cnt[exp_ix]++; m_va[exp_ix] = va;
        end
        @(negedge clk);
        alloc_valid = 1'b0; free_valid = 1'b0;
        #1;
        if (av && fv)           tag = "R9";
        else if (fv && hit < -1) tag = "R7";
        else if (fv)            tag = "R8";
        else                    tag = "R2";
        check(occupancy == 4'(m_occ), tag, "occupancy", occupancy, m_occ);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin m_busy[i] = 0; m_cnt[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(occupancy == 4'd0, "R1", "occupancy after reset", occupancy, 0);

        // kind-pair sweep with flavour bits: open, same line (low bits differ), release
        for (int p = 0; p < 8; p++) begin
            for (int q = 0; q < 8; q++) begin
                cyc(1, 32'h0001_0000 + 32'(p*64 + q*8), 3'(p), 2'(p), 3'd1, 32'h100 + 32'(q), 0, 0);
                cyc(1, 32'h0001_0005 + 32'(p*64 + q*8), 3'(q), 2'd0, 3'd2, 32'h200 + 32'(p), 0, 0);
                cyc(0, 0, 0, 0, 0, 0, 1, 0);
            end
        end

        // waiter list fills up: three merges, fourth shared request conflicts (R6)
        cyc(1, 32'h0002_0000, 3'b001, 2'd3, 3'd5, 32'hA0, 0, 0);
        for (int k = 1; k <= 4; k++)
            cyc(1, 32'h0002_0000 + 32'(k), 3'b000, 2'd1, 3'(k + 1), 32'hA0 + 32'(k), 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 0);   // R8: slot 0 already free

        // fill every slot, then one more distinct line is full (R3)
        for (int i = 0; i < N; i++)
            cyc(1, 32'h0003_0000 + 32'(i*16), 3'(i % 2), 2'(i), 3'(i), 32'(i), 0, 0);
        cyc(1, 32'h0004_0000, 3'b000, 2'd0, 3'd0, 32'h0, 0, 0);

        // R9: freed slot not reused in the same cycle
        cyc(1, 32'h0004_0000, 3'b000, 2'd0, 3'd6, 32'h44, 1, 3);
        cyc(1, 32'h0004_0000, 3'b000, 2'd0, 3'd6, 32'h44, 0, 0);
        // R9: same line as the slot being freed is not merged
        cyc(1, 32'h0003_0050, 3'b000, 2'd2, 3'd7, 32'h55, 1, 5);
        cyc(1, 32'h0003_0050, 3'b000, 2'd2, 3'd7, 32'h55, 0, 0);
        // merge into another slot while one is released
        cyc(1, 32'h0003_0020, 3'b000, 2'd0, 3'd4, 32'h66, 1, 6);
        cyc(0, 0, 0, 0, 0, 0, 1, 6);   // R8 again
        for (int i = 0; i < N; i++) cyc(0, 0, 0, 0, 0, 0, 1, i);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule